// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block divides the system clock into time quanta and strings those quanta into CAN bit periods. Each bit opens with a one-quantum sync segment, followed by a first phase segment and a second phase segment. The lengths come from two 8-bit configuration bytes. The receive line is sampled at the end of the first phase segment, either once or as a two-of-three majority over the last three quantum boundaries. A recessive-to-dominant transition on the line keeps the local bit period aligned with the transmitting node.

While the bus is idle, frame logic raises `hsync_en`. A qualifying falling edge then restarts the bit timing outright, and a fresh sync segment begins. Inside a frame, the same kind of edge resynchronizes instead. An edge late in the first segment stretches that segment. An edge early in the second segment either restarts the bit or cuts the second segment short. The correction never exceeds the programmed jump width. Downstream logic takes the sampled bit on `sample_stb` and starts transmit bits on `bit_start_stb`.

Top module: `can_bit_timer`

## Requirements
- R1: After reset, `rx_bit` is 1, and `sample_stb` and `bit_start_stb` are both 0.
- R2: One quantum is 2·(P+1) system clocks, where P = `cfg_timing0[5:0]`. A bit with no correction lasts 1 + (A+1) + (B+1) quanta, where A = `cfg_timing1[3:0]` and B = `cfg_timing1[6:4]`. With `cfg_timing0`=0xC2 and `cfg_timing1`=0x3A, `bit_start_stb` repeats every 96 clocks.
- R3: The sample point is the end of the first phase segment. `sample_stb` pulses (1+A+1)·2·(P+1) clocks after `bit_start_stb` when no correction applies. `rx_bit` changes only in the cycle in which `sample_stb` is 1.
- R4: `cfg_timing1[7]`=0 selects one sample, taken at the sample point. `cfg_timing1[7]`=1 selects the majority of the line values at the last three quantum boundaries up to and including the sample point. In majority mode, a recessive spike no longer than one quantum on a dominant line never reaches `rx_bit`.
- R5: With `hsync_en`=1, a qualifying falling edge restarts the timing. `bit_start_stb` is 1 two clocks after the line change is applied at the `rx_line` port, and the new bit then runs its full nominal length.
- R6: A falling edge qualifies only while `rx_bit` is 1. A falling edge seen while `rx_bit` is 0 leaves the bit timing unchanged.
- R7: Let J = `cfg_timing0[7:6]`+1. An edge in quantum k (k ≥ 1) of the first phase segment lengthens that segment by min(k, J) quanta.
- R8: An edge in the second phase segment has magnitude m, the number of quanta from the edge's quantum to the end of the bit inclusive. If m ≤ J, the timing restarts as in R5. Otherwise the second segment is shortened by J quanta.
- R9: An edge in the sync segment changes nothing. Only the first qualifying edge in a bit acts when `hsync_en` is 0.
- R10: `bit_start_stb` is a one-clock pulse at the start of each sync segment and never coincides with `sample_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Raw receive line, 1 = recessive |
| cfg_timing0 | input | 8 | Jump width [7:6], prescaler [5:0] |
| cfg_timing1 | input | 8 | Sample mode [7], second segment [6:4], first segment [3:0] |
| hsync_en | input | 1 | Hard synchronization allowed (bus idle) |
| rx_bit | output | 1 | Last sampled bit value |
| sample_stb | output | 1 | One-clock pulse when `rx_bit` is updated |
| bit_start_stb | output | 1 | One-clock pulse at each sync segment start |

## Verification
A wrong quantum count or segment length shows up within one bit period as a shifted `bit_start_stb` or `sample_stb`. A mis-clamped or doubly applied correction stretches or shortens the very next bit by whole quanta. A broken majority vote or a lost sampled value shows up as a wrong `rx_bit` at the next sample strobe. After that, edge qualification goes wrong and timing drifts over the following bits. A clock-by-clock reference model therefore catches most internal faults within one to two bit periods of the stimulus that exposes them.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int PRESC_W = 6;
  localparam int SJW_W   = 2;
  localparam int TS1_W   = 4;
  localparam int TS2_W   = 3;
  localparam int PCNT_W  = PRESC_W + 2;
  localparam int QCNT_W  = TS1_W + 1;

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SEG1 = 2'd1,
    PH_SEG2 = 2'd2
  } phase_t;

  // system clocks per quantum: 2*(brp+1)
  function automatic logic [PCNT_W-1:0] tq_clocks(input logic [PRESC_W-1:0] brp);
    return {1'b0, brp, 1'b0} + PCNT_W'(2);
  endfunction

  // register field to length in quanta
  function automatic logic [QCNT_W-1:0] field_len(input logic [QCNT_W-1:0] f);
    return f + QCNT_W'(1);
  endfunction

  function automatic logic [QCNT_W-1:0] min_q(input logic [QCNT_W-1:0] a,
                                              input logic [QCNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler
  import cbt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] brp,
  input  logic               restart,
  output logic               tq_tick
);
  logic [PCNT_W-1:0] pcnt;
  logic [PCNT_W-1:0] last_cnt;

  assign last_cnt = tq_clocks(brp) - PCNT_W'(1);
  assign tq_tick  = (pcnt == last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)                  pcnt <= '0;
    else if (restart || tq_tick) pcnt <= '0;
    else                         pcnt <= pcnt + PCNT_W'(1);
  end
endmodule

// File: rtl/cbt_edge_det.sv
module cbt_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  input  logic last_bit,
  output logic rx_now,
  output logic fall_ev
);
  logic rx_q, rx_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q <= 1'b1;
      rx_d <= 1'b1;
    end else begin
      rx_q <= rx_line;
      rx_d <= rx_q;
    end
  end

  assign rx_now  = rx_q;
  // recessive-to-dominant, counted only after a recessive sampled bit
  assign fall_ev = rx_d & ~rx_q & last_bit;
endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler
  import cbt_pkg::*;
#(
  parameter int HIST_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tq_tick,
  input  logic restart,
  input  logic at_sample,
  input  logic rx_now,
  input  logic triple,
  output logic rx_bit,
  output logic sample_stb
);
  logic [HIST_N-1:0] hist;
  logic              voted;

  assign voted = triple ? maj3(hist[1], hist[0], rx_now) : rx_now;

  // line history at quantum boundaries
  genvar g;
  generate
    for (g = 0; g < HIST_N; g++) begin : g_hist
      always_ff @(posedge clk) begin
        if (!rst_n)                   hist[g] <= 1'b1;
        else if (tq_tick && !restart) hist[g] <= (g == 0) ? rx_now : hist[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_bit     <= 1'b1;
      sample_stb <= 1'b0;
    end else begin
      sample_stb <= at_sample;
      if (at_sample) rx_bit <= voted;
    end
  end
endmodule

// File: rtl/cbt_phase_fsm.sv
module cbt_phase_fsm
  import cbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tq_tick,
  input  logic              fall_ev,
  input  logic              hsync_en,
  input  logic [TS1_W-1:0]  ts1,
  input  logic [TS2_W-1:0]  ts2,
  input  logic [SJW_W-1:0]  jw,
  output logic              restart,
  output logic              at_sample,
  output logic              neg_restart,
  output logic              bit_start_stb,
  output phase_t            phase,
  output logic [QCNT_W-1:0] qcnt
);
  logic [QCNT_W-1:0] t1, t2, sjw;
  logic [QCNT_W-1:0] ext_r, shr_r, ext_now, shr_now;
  logic [QCNT_W-1:0] seg1_len, seg2_len, e_pos, mag_neg;
  logic              done_r, do_hard, do_resync, pos_case, neg_case;
  logic              seg1_last, seg2_last;

  assign t1  = field_len(QCNT_W'(ts1));
  assign t2  = field_len(QCNT_W'(ts2));
  assign sjw = field_len(QCNT_W'(jw));

  assign e_pos   = qcnt + QCNT_W'(1);
  assign mag_neg = t2 - qcnt;

  assign do_hard     = fall_ev & hsync_en;
  assign do_resync   = fall_ev & ~hsync_en & ~done_r;
  assign pos_case    = do_resync & (phase == PH_SEG1);
  assign neg_case    = do_resync & (phase == PH_SEG2);
  assign neg_restart = neg_case & (mag_neg <= sjw);
  assign restart     = do_hard | neg_restart;

  assign ext_now  = pos_case ? min_q(e_pos, sjw) : ext_r;
  assign shr_now  = (neg_case && !neg_restart) ? sjw : shr_r;
  assign seg1_len = t1 + ext_now;
  assign seg2_len = t2 - shr_now;

  assign seg1_last = (qcnt == seg1_len - QCNT_W'(1));
  assign seg2_last = (qcnt == seg2_len - QCNT_W'(1));
  assign at_sample = tq_tick & ~restart & (phase == PH_SEG1) & seg1_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase         <= PH_SYNC;
      qcnt          <= '0;
      ext_r         <= '0;
      shr_r         <= '0;
      done_r        <= 1'b0;
      bit_start_stb <= 1'b0;
    end else if (restart) begin
      phase         <= PH_SYNC;
      qcnt          <= '0;
      ext_r         <= '0;
      shr_r         <= '0;
      done_r        <= 1'b1;
      bit_start_stb <= 1'b1;
    end else begin
      bit_start_stb <= 1'b0;
      ext_r         <= ext_now;
      shr_r         <= shr_now;
      if (do_resync) done_r <= 1'b1;
      if (tq_tick) begin
        unique case (phase)
          PH_SYNC: begin
            phase <= PH_SEG1;
            qcnt  <= '0;
          end
          PH_SEG1: begin
            if (seg1_last) begin
              phase <= PH_SEG2;
              qcnt  <= '0;
            end else begin
              qcnt <= qcnt + QCNT_W'(1);
            end
          end
          PH_SEG2: begin
            if (seg2_last) begin
              phase         <= PH_SYNC;
              qcnt          <= '0;
              ext_r         <= '0;
              shr_r         <= '0;
              done_r        <= 1'b0;
              bit_start_stb <= 1'b1;
            end else begin
              qcnt <= qcnt + QCNT_W'(1);
            end
          end
          default: begin
            phase <= PH_SYNC;
            qcnt  <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import cbt_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  input  logic [CFG_W-1:0] cfg_timing0,
  input  logic [CFG_W-1:0] cfg_timing1,
  input  logic             hsync_en,
  output logic             rx_bit,
  output logic             sample_stb,
  output logic             bit_start_stb
);
  localparam int MODE_POS = TS1_W + TS2_W;

  logic [PRESC_W-1:0] brp;
  logic [SJW_W-1:0]   jw;
  logic [TS1_W-1:0]   ts1;
  logic [TS2_W-1:0]   ts2;
  logic               triple;

  assign brp    = cfg_timing0[PRESC_W-1:0];
  assign jw     = cfg_timing0[PRESC_W +: SJW_W];
  assign ts1    = cfg_timing1[TS1_W-1:0];
  assign ts2    = cfg_timing1[TS1_W +: TS2_W];
  assign triple = cfg_timing1[MODE_POS];

  logic              tq_tick, restart, at_sample, neg_restart;
  logic              rx_now, fall_ev;
  phase_t            phase;
  logic [QCNT_W-1:0] qcnt;

  cbt_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .brp(brp), .restart(restart), .tq_tick(tq_tick)
  );

  cbt_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .last_bit(rx_bit),
    .rx_now(rx_now), .fall_ev(fall_ev)
  );

  cbt_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .fall_ev(fall_ev),
    .hsync_en(hsync_en), .ts1(ts1), .ts2(ts2), .jw(jw),
    .restart(restart), .at_sample(at_sample), .neg_restart(neg_restart),
    .bit_start_stb(bit_start_stb), .phase(phase), .qcnt(qcnt)
  );

  cbt_sampler #(.HIST_N(2)) u_samp (
    .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .restart(restart),
    .at_sample(at_sample), .rx_now(rx_now), .triple(triple),
    .rx_bit(rx_bit), .sample_stb(sample_stb)
  );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker
  import cbt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cfg_timing0,
  input logic [7:0]        cfg_timing1,
  input logic              hsync_en,
  input logic              rx_bit,
  input logic              sample_stb,
  input logic              bit_start_stb,
  input logic              fall_ev,
  input logic              neg_restart,
  input phase_t            phase,
  input logic [QCNT_W-1:0] qcnt
);
  logic [QCNT_W:0] seg1_max, seg2_max;
  assign seg1_max = {2'b00, cfg_timing1[3:0]} + {4'b0000, cfg_timing0[7:6]} + (QCNT_W+1)'(2);
  assign seg2_max = {3'b000, cfg_timing1[6:4]} + (QCNT_W+1)'(1);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_start_stb));

  // R10
  bstart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start_stb |=> !bit_start_stb);

  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> $stable(rx_bit));

  // R5
  hard_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && hsync_en) |=> bit_start_stb);

  // R8
  neg_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    neg_restart |=> (bit_start_stb && phase == PH_SYNC));

  // R7
  seg1_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SEG1) |-> ({1'b0, qcnt} < seg1_max));

  // R8
  seg2_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SEG2) |-> ({1'b0, qcnt} < seg2_max));
endmodule

bind can_bit_timer cbt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_timing0(cfg_timing0), .cfg_timing1(cfg_timing1),
  .hsync_en(hsync_en), .rx_bit(rx_bit), .sample_stb(sample_stb),
  .bit_start_stb(bit_start_stb), .fall_ev(fall_ev), .neg_restart(neg_restart),
  .phase(phase), .qcnt(qcnt)
);

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       hsync_en = 1'b0;
  logic [7:0] c0 = 8'hC2;
  logic [7:0] c1 = 8'h3A;
  wire        rx_bit, sample_stb, bit_start_stb;

  always #2 clk = ~clk;

  can_bit_timer i_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .cfg_timing0(c0),
    .cfg_timing1(c1), .hsync_en(hsync_en), .rx_bit(rx_bit),
    .sample_stb(sample_stb), .bit_start_stb(bit_start_stb)
  );

  int  tests = 0;
  int  fails = 0;
  bit  cmp_on = 0;
  bit  done_run = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: absolute quantum position within the bit
  int  m_pc, m_pos, m_ext, m_shr;
  bit  m_done, m_rxq, m_rxd, m_bit, m_sstb, m_bstb, m_h0, m_h1;

  always @(posedge clk) begin
    int qlen, t1, t2, sj, sp, last_pos, mag;
    bit tick, edge_seen, restart, ns, nb, v;
    if (!rst_n) begin
      m_pc = 0; m_pos = 0; m_ext = 0; m_shr = 0; m_done = 0;
      m_rxq = 1; m_rxd = 1; m_bit = 1; m_sstb = 0; m_bstb = 0; m_h0 = 1; m_h1 = 1;
    end else begin
      qlen = 2 * (int'(c0[5:0]) + 1);
      t1 = int'(c1[3:0]) + 1;
      t2 = int'(c1[6:4]) + 1;
      sj = int'(c0[7:6]) + 1;
      tick = (m_pc == qlen - 1);
      edge_seen = m_rxd && !m_rxq && m_bit;
      restart = 0; ns = 0; nb = 0;
      if (edge_seen && hsync_en) restart = 1;
      else if (edge_seen && !m_done) begin
        m_done = 1;
        if (m_pos >= 1 && m_pos <= t1) m_ext = (m_pos < sj) ? m_pos : sj;
        else if (m_pos > t1) begin
          mag = 1 + t1 + t2 - m_pos;
          if (mag <= sj) restart = 1; else m_shr = sj;
        end
      end
      if (restart) begin
        m_pc = 0; m_pos = 0; m_ext = 0; m_shr = 0; m_done = 1; nb = 1;
      end else if (tick) begin
        m_pc = 0;
        sp = t1 + m_ext;
        last_pos = t1 + m_ext + t2 - m_shr;
        if (m_pos == sp) begin
          v = c1[7] ? ((m_h1 & m_h0) | (m_h1 & m_rxq) | (m_h0 & m_rxq)) : m_rxq;
          m_bit = v; ns = 1;
        end
        m_h1 = m_h0; m_h0 = m_rxq;
        if (m_pos == last_pos) begin
          m_pos = 0; m_ext = 0; m_shr = 0; m_done = 0; nb = 1;
        end else m_pos++;
      end else m_pc++;
      m_sstb = ns; m_bstb = nb;
      m_rxd = m_rxq; m_rxq = rx_line;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check(rx_bit == m_bit, "R4", "model rx_bit", int'(rx_bit), int'(m_bit));
      check(sample_stb == m_sstb, "R3", "model sample_stb", int'(sample_stb), int'(m_sstb));
      check(bit_start_stb == m_bstb, "R2", "model bit_start_stb", int'(bit_start_stb), int'(m_bstb));
    end
  end

  task automatic wait_bstart(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!bit_start_stb && n < 2000);
  endtask

  task automatic settle(input int nbits);
    int d;
    rx_line = 1'b1;
    for (int i = 0; i < nbits; i++) wait_bstart(d);
  endtask

  // edge d clocks after a bit start; optional second edge in same bit
  task automatic edge_spacing(input int d, input bit second, output int sp);
    int dummy;
    wait_bstart(dummy);
    repeat (d) @(negedge clk);
    rx_line = 1'b0;
    sp = d;
    do begin
      @(negedge clk); sp++;
      if (second && sp == d + 5)  rx_line = 1'b1;
      if (second && sp == d + 10) rx_line = 1'b0;
    end while (!bit_start_stb && sp < 2000);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      check(0, "ALL", "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int sp, n, ones, bad, lfsr, len;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(rx_bit == 1'b1, "R1", "reset rx_bit", int'(rx_bit), 1);
    check(sample_stb == 1'b0, "R1", "reset sample_stb", int'(sample_stb), 0);
    check(bit_start_stb == 1'b0, "R1", "reset bit_start_stb", int'(bit_start_stb), 0);
    do_reset();
    cmp_on = 1;

    // R2 nominal period 96 clocks for 0xC2/0x3A
    wait_bstart(n); wait_bstart(n);
    check(n == 96, "R2", "bit period C2/3A", n, 96);

    // R7 late edges, clamped at jump width 4
    settle(3); edge_spacing(7, 0, sp);
    check(sp == 102, "R7", "edge in seg1 q1", sp, 102);
    settle(3); edge_spacing(37, 0, sp);
    check(sp == 120, "R7", "edge in seg1 q6 clamped", sp, 120);
    // R9 edge in sync segment, and a second edge in one bit
    settle(3); edge_spacing(2, 0, sp);
    check(sp == 96, "R9", "edge in sync segment", sp, 96);
    settle(3); edge_spacing(13, 1, sp);
    check(sp == 108, "R9", "second edge ignored", sp, 108);
    // R8 early edge within jump width restarts
    settle(3); edge_spacing(85, 0, sp);
    check(sp == 87, "R8", "seg2 edge restart", sp, 87);

    // jump width 1
    c0 = 8'h02; do_reset();
    settle(3); edge_spacing(73, 0, sp);
    check(sp == 90, "R8", "seg2 shortened by J=1", sp, 90);
    settle(3); edge_spacing(19, 0, sp);
    check(sp == 102, "R7", "seg1 clamp J=1", sp, 102);

    // R5 hard sync and R3 sample point delay
    c0 = 8'hC2; do_reset(); settle(2);
    hsync_en = 1'b1;
    repeat (31) @(negedge clk);
    rx_line = 1'b0;
    @(negedge clk);
    check(bit_start_stb == 1'b0, "R5", "no strobe one clock after edge", int'(bit_start_stb), 0);
    @(negedge clk);
    check(bit_start_stb == 1'b1, "R5", "strobe two clocks after edge", int'(bit_start_stb), 1);
    hsync_en = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_stb && n < 500);
    check(n == 72, "R3", "sample delay after bit start", n, 72);
    check(rx_bit == 1'b0, "R3", "sampled dominant", int'(rx_bit), 0);
    wait_bstart(n);
    check(n == 24, "R5", "rest of synced bit", n, 24);

    // R4/R6 majority mode suppresses one-quantum recessive spikes
    c1 = 8'hBA; do_reset();
    hsync_en = 1'b1; rx_line = 1'b1; repeat (200) @(negedge clk);
    rx_line = 1'b0; repeat (4) @(negedge clk); hsync_en = 1'b0;
    wait_bstart(n); wait_bstart(n);
    ones = 0; bad = 0;
    for (int k = 0; k < 40 * 96; k++) begin
      rx_line = ((k % 25) < 6) ? 1'b1 : 1'b0;
      @(negedge clk);
      if (sample_stb && rx_bit) ones++;
      if (bit_start_stb && (k % 96) != 95) bad++;
    end
    check(ones == 0, "R4", "spikes passed majority", ones, 0);
    check(bad == 0, "R6", "timing moved by unqualified edges", bad, 0);

    // R4 single mode sees the same spikes
    c1 = 8'h3A; do_reset();
    hsync_en = 1'b1; rx_line = 1'b1; repeat (200) @(negedge clk);
    rx_line = 1'b0; repeat (4) @(negedge clk); hsync_en = 1'b0;
    wait_bstart(n); wait_bstart(n);
    ones = 0;
    for (int k = 0; k < 40 * 96; k++) begin
      rx_line = ((k % 25) < 6) ? 1'b1 : 1'b0;
      @(negedge clk);
      if (sample_stb && rx_bit) ones++;
    end
    check(ones > 0, "R4", "single mode catches spike", ones, 1);

    // R2 small configuration: 2-clock quantum, 5-quantum bit
    c0 = 8'h00; c1 = 8'h11; rx_line = 1'b1; do_reset();
    wait_bstart(n); wait_bstart(n);
    check(n == 10, "R2", "bit period 00/11", n, 10);

    // mixed streams with drifting bit lengths, both modes (model compare, R10)
    lfsr = 32'h1ACE;
    for (int f = 0; f < 8; f++) begin
      c0 = (f % 2) ? 8'h82 : 8'hC2;
      c1 = (f % 3 == 0) ? 8'hBA : 8'h3A;
      do_reset();
      rx_line = 1'b1; hsync_en = 1'b1;
      repeat (250) @(negedge clk);
      for (int b = 0; b < 24; b++) begin
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
        len = 90 + (lfsr % 13);
        rx_line = (b == 0) ? 1'b0 : lfsr[4];
        if (b == 1) hsync_en = 1'b0;
        repeat (len) @(negedge clk);
      end
    end
    rx_line = 1'b1;
    repeat (300) @(negedge clk);

    done_run = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule